// File: doc/BRIEF.md
# Reorder Buffer with Precise Recovery

This block keeps the in-flight window of an out-of-order core in program order. Each instruction takes one slot at the tail when it leaves rename. The slot records its program counter, its destination register, whether it writes a register and whether it was fetched past a predicted branch. Execution units report results in any order through a completion port that carries the slot index, the result byte and an exception flag. The block retires the oldest slot once it is done, at most one per cycle, and only then writes the result into a small architectural register file. That file therefore always holds the committed, in-order state.

Two recovery paths keep that state precise. When the oldest slot is done with an exception, nothing is written: every slot is discarded and the faulting program counter is shown for one cycle, so execution can restart at that instruction. When a branch resolves as mispredicted, the branch slot is marked done so that it retires in its turn, and every slot younger than it is dropped at once. The next allocation then lands in the slot just after the branch.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty, `full` is 0, `alloc_idx` is 0 and `exc_valid` is 0. With the default `RST_TO_INDEX`=1, architectural register r holds the value r. With 0 it holds zero.
- R2: Each accepted allocation takes the slot shown on `alloc_idx`, and `alloc_idx` then steps by one modulo DEPTH. Slots retire strictly in allocation order, at most one per clock edge.
- R3: The register file changes only when the oldest slot is valid, done, free of an exception and has its write flag set. That write happens on the first clock edge at which the oldest slot is seen done, and a slot that is not done holds back every slot behind it.
- R4: Completions may arrive in any order. Register results still reach the file in program order, so when two slots write the same register, the younger value remains.
- R5: `full` is 1 while DEPTH slots are occupied. An allocation request while full is dropped and leaves `alloc_idx` unchanged.
- R6: A completion addressed to a slot that is not valid has no effect. A later allocation of that slot starts not done.
- R7: When the oldest slot is done with its exception flag set, the next clock edge writes nothing. That edge raises `exc_valid` for exactly one cycle, with `exc_pc` equal to that slot's program counter.
- R8: The exception edge also discards every slot, including completed younger ones whose results never reach the file. The buffer is then empty and `alloc_idx` equals the faulting slot's index.
- R9: A misprediction on valid slot k marks k done, so that it retires in order without a register write when its write flag is 0. It drops every slot younger than k and sets `alloc_idx` to k+1 modulo DEPTH on the same edge. An allocation in that cycle is dropped.
- R10: Slots allocated after a predicted branch carry the speculative flag, and only such slots may be squashed by a misprediction. A completion to a squashed slot is ignored, and its result never reaches the file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Request to allocate one slot |
| alloc_pc | input | PCW | Program counter of the allocated instruction |
| alloc_dst | input | log2(NREG) | Destination register |
| alloc_wr | input | 1 | Instruction writes its destination register |
| alloc_spec | input | 1 | Instruction lies past a predicted branch |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation takes (tail) |
| full | output | 1 | All DEPTH slots occupied |
| cmpl_valid | input | 1 | Completion write request |
| cmpl_idx | input | log2(DEPTH) | Slot being completed |
| cmpl_data | input | DW | Result value |
| cmpl_exc | input | 1 | Instruction raised an exception |
| mp_valid | input | 1 | Branch misprediction resolved |
| mp_idx | input | log2(DEPTH) | Slot of the mispredicted branch |
| exc_valid | output | 1 | One-cycle pulse: precise exception taken |
| exc_pc | output | PCW | Program counter of the faulting instruction |
| arf_q | output | NREG*DW | Architectural registers, register r at bits r*DW and up |

## Verification
An allocation or squash is visible on `alloc_idx` and `full` right after the edge that takes it. A completion of the oldest slot at edge E shows up in the register file after edge E+1. An exception completed at edge E raises `exc_valid` after edge E+1 and drops it after E+2. The bench drives on falling edges, counts these edges in its tasks and samples on the falling edge after the edge due. It checks the value one cycle before as well, where a late or early result would show. A table of writes completed in reverse order exercises the in-order rule. Directed sequences then cover full rejection, stray completions, the exception pulse and misprediction squash.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef struct packed {
      logic valid;
      logic spec;
      logic done;
      logic exc;
      logic wr;
   } rob_flags_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
   parameter int DEPTH = 8,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          flush,
   input  logic          redirect,
   input  logic [PW-1:0] redirect_idx,
   output logic [PW-1:0] head_idx,
   output logic [PW-1:0] tail_idx,
   output logic          full,
   output logic          empty
);
   localparam logic [PW:0] ONE = (PW+1)'(1);
   localparam logic [PW:0] CAP = (PW+1)'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("rob_ptrs: DEPTH must be a power of two of at least 2");
   end

   logic [PW:0]   head_q, tail_q, head_d, tail_d, occ;
   logic [PW-1:0] rel_br;

   assign occ      = tail_q - head_q;
   assign full     = (occ == CAP);
   assign empty    = (occ == '0);
   assign head_idx = head_q[PW-1:0];
   assign tail_idx = tail_q[PW-1:0];
   assign rel_br   = redirect_idx - head_q[PW-1:0];

   always_comb begin
      head_d = pop ? head_q + ONE : head_q;
      if (flush)         tail_d = head_q;
      else if (redirect) tail_d = head_q + {1'b0, rel_br} + ONE;
      else if (push)     tail_d = tail_q + ONE;
      else               tail_d = tail_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_d;
         tail_q <= tail_d;
      end
   end

   // R2: the head moves forward by zero or one slot per edge
   assert_head_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (head_q == $past(head_q)) || (head_q == $past(head_q) + ONE))
      else $error("head pointer jumped");

   // R5: occupancy never exceeds the capacity
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_q - head_q) <= CAP)
      else $error("occupancy above DEPTH");
endmodule

// File: rtl/rob_arf.sv
module rob_arf #(
   parameter int NREG = 8,
   parameter int DW = 8,
   parameter bit RST_TO_INDEX = 1'b1,
   localparam int AW = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [AW-1:0]      waddr,
   input  logic [DW-1:0]      wdata,
   output logic [NREG*DW-1:0] regs_flat
);
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_chk_nreg
      $error("rob_arf: NREG must be a power of two of at least 2");
   end
   if (RST_TO_INDEX && NREG > (1 << DW)) begin : g_chk_init
      $error("rob_arf: DW too narrow to hold register indices");
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam logic [AW-1:0] ADDR = AW'(r);
      logic [DW-1:0] q;
      if (RST_TO_INDEX) begin : g_rst_idx
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    q <= DW'(r);
            else if (we && waddr == ADDR)  q <= wdata;
         end
      end else begin : g_rst_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    q <= '0;
            else if (we && waddr == ADDR)  q <= wdata;
         end
      end
      assign regs_flat[r*DW +: DW] = q;
   end

   // R3: without a retire write the committed state holds
   assert_arf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(regs_flat))
      else $error("architectural state changed without a retire");
endmodule

// File: rtl/rob_core.sv
module rob_core #(
   parameter int DEPTH = 8,
   parameter int NREG = 8,
   parameter int DW = 8,
   parameter int PCW = 16,
   parameter bit RST_TO_INDEX = 1'b1,
   localparam int PW = $clog2(DEPTH),
   localparam int AW = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alloc_valid,
   input  logic [PCW-1:0]     alloc_pc,
   input  logic [AW-1:0]      alloc_dst,
   input  logic               alloc_wr,
   input  logic               alloc_spec,
   output logic [PW-1:0]      alloc_idx,
   output logic               full,
   input  logic               cmpl_valid,
   input  logic [PW-1:0]      cmpl_idx,
   input  logic [DW-1:0]      cmpl_data,
   input  logic               cmpl_exc,
   input  logic               mp_valid,
   input  logic [PW-1:0]      mp_idx,
   output logic               exc_valid,
   output logic [PCW-1:0]     exc_pc,
   output logic [NREG*DW-1:0] arf_q
);
   import rob_pkg::*;

   if (DW < 1 || PCW < 1) begin : g_chk_widths
      $error("rob_core: DW and PCW must be positive");
   end

   logic [PW-1:0] head_idx, tail_idx, rel_br;
   logic          empty;
   logic          do_retire, do_flush, do_redirect, do_push;
   logic [DEPTH-1:0] younger, valid_v, spec_v, done_v;

   rob_flags_t    flg   [DEPTH];
   logic [PCW-1:0] pc_a  [DEPTH];
   logic [AW-1:0]  dst_a [DEPTH];
   logic [DW-1:0]  dat_a [DEPTH];
   rob_flags_t    head_f;

   // Oldest-slot decisions: an exception flush outranks a misprediction,
   // which outranks a new allocation.
   assign head_f      = flg[head_idx];
   assign do_retire   = head_f.valid && head_f.done && !head_f.exc;
   assign do_flush    = head_f.valid && head_f.done && head_f.exc;
   assign do_redirect = mp_valid && !do_flush && flg[mp_idx].valid;
   assign do_push     = alloc_valid && !full && !do_flush && !do_redirect;
   assign rel_br      = mp_idx - head_idx;
   assign alloc_idx   = tail_idx;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         younger[i] = (PW'(i) - head_idx) > rel_br;
         valid_v[i] = flg[i].valid;
         spec_v[i]  = flg[i].spec;
         done_v[i]  = flg[i].done;
      end
   end

   rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk          (clk),
      .rst_n        (rst_n),
      .push         (do_push),
      .pop          (do_retire),
      .flush        (do_flush),
      .redirect     (do_redirect),
      .redirect_idx (mp_idx),
      .head_idx     (head_idx),
      .tail_idx     (tail_idx),
      .full         (full),
      .empty        (empty)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam logic [PW-1:0] SLOT = PW'(i);
      rob_flags_t     f_q;
      logic [PCW-1:0] pc_r;
      logic [AW-1:0]  dst_r;
      logic [DW-1:0]  dat_r;
      logic           hit_push, hit_cmpl;

      assign hit_push = do_push && (tail_idx == SLOT);
      assign hit_cmpl = cmpl_valid && (cmpl_idx == SLOT) && f_q.valid;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q   <= '0;
            pc_r  <= '0;
            dst_r <= '0;
            dat_r <= '0;
         end else if (do_flush) begin
            f_q.valid <= 1'b0;
         end else if (do_redirect && younger[i]) begin
            f_q.valid <= 1'b0;
         end else if (hit_push) begin
            f_q   <= rob_flags_t'{valid: 1'b1, spec: alloc_spec, done: 1'b0,
                                  exc: 1'b0, wr: alloc_wr};
            pc_r  <= alloc_pc;
            dst_r <= alloc_dst;
         end else begin
            if (do_retire && head_idx == SLOT) f_q.valid <= 1'b0;
            if (do_redirect && mp_idx == SLOT) begin
               f_q.done <= 1'b1;
               f_q.exc  <= 1'b0;
            end else if (hit_cmpl) begin
               f_q.done <= 1'b1;
               f_q.exc  <= cmpl_exc;
               dat_r    <= cmpl_data;
            end
         end
      end

      assign flg[i]   = f_q;
      assign pc_a[i]  = pc_r;
      assign dst_a[i] = dst_r;
      assign dat_a[i] = dat_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_valid <= 1'b0;
         exc_pc    <= '0;
      end else begin
         exc_valid <= do_flush;
         if (do_flush) exc_pc <= pc_a[head_idx];
      end
   end

   rob_arf #(.NREG(NREG), .DW(DW), .RST_TO_INDEX(RST_TO_INDEX)) u_arf (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (do_retire && head_f.wr),
      .waddr     (dst_a[head_idx]),
      .wdata     (dat_a[head_idx]),
      .regs_flat (arf_q)
   );

   // R5: a request while full leaves the tail where it was
   assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      full && alloc_valid && !mp_valid |=> $stable(alloc_idx))
      else $error("allocation accepted while full");

   // R6: completing an invalid slot never leaves it valid and done
   assert_cmpl_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_valid && !valid_v[cmpl_idx] |=>
         !valid_v[$past(cmpl_idx)] || !done_v[$past(cmpl_idx)])
      else $error("completion to an invalid slot took effect");

   // R7: the exception indication lasts a single cycle
   assert_exc_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> !exc_valid)
      else $error("exception pulse longer than one cycle");

   // R8: the exception cycle finds the buffer drained
   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> empty && !full)
      else $error("slots survived an exception flush");

   // R10: a misprediction only squashes speculative slots
   assert_squash_spec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      do_redirect |-> (younger & valid_v & ~spec_v) == '0)
      else $error("non-speculative slot younger than a branch");
endmodule

// File: tb/sim_rob_core.sv
module sim_rob_core;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int NREG  = 8;
   localparam int DW    = 8;
   localparam int PCW   = 16;
   localparam int PW    = 3;
   localparam int AW    = 3;
   localparam int NVEC  = 6;
   // each row: destination register, result value
   localparam logic [AW+DW-1:0] VEC [NVEC] = '{
      {3'd5, 8'h11}, {3'd2, 8'h22}, {3'd5, 8'h33},
      {3'd7, 8'h44}, {3'd2, 8'h55}, {3'd0, 8'h66}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_valid = 0, alloc_wr = 0, alloc_spec = 0;
   logic [PCW-1:0] alloc_pc = '0;
   logic [AW-1:0]  alloc_dst = '0;
   logic [PW-1:0]  alloc_idx;
   logic           full;
   logic cmpl_valid = 0, cmpl_exc = 0, mp_valid = 0;
   logic [PW-1:0]  cmpl_idx = '0, mp_idx = '0;
   logic [DW-1:0]  cmpl_data = '0;
   logic           exc_valid;
   logic [PCW-1:0] exc_pc;
   logic [NREG*DW-1:0] arf_q;

   rob_core #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW), .PCW(PCW)) u0 (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_pc(alloc_pc),
      .alloc_dst(alloc_dst), .alloc_wr(alloc_wr), .alloc_spec(alloc_spec),
      .alloc_idx(alloc_idx), .full(full), .cmpl_valid(cmpl_valid),
      .cmpl_idx(cmpl_idx), .cmpl_data(cmpl_data), .cmpl_exc(cmpl_exc),
      .mp_valid(mp_valid), .mp_idx(mp_idx), .exc_valid(exc_valid),
      .exc_pc(exc_pc), .arf_q(arf_q));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0;
   bit finished = 0;
   logic [DW-1:0] mdl [NREG];

   function automatic logic [DW-1:0] arf_rd(int r);
      return arf_q[r*DW +: DW];
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_arf(string tag);
      for (int r = 0; r < NREG; r++) chk(tag, 32'(arf_rd(r)), 32'(mdl[r]));
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic alloc(input logic [PCW-1:0] pc, input logic [AW-1:0] dst,
                        input logic wr, input logic spec, output logic [PW-1:0] idx);
      idx = alloc_idx;
      alloc_valid = 1; alloc_pc = pc; alloc_dst = dst; alloc_wr = wr; alloc_spec = spec;
      tick();
      alloc_valid = 0;
   endtask

   task automatic cmpl(input logic [PW-1:0] idx, input logic [DW-1:0] d, input logic e);
      cmpl_valid = 1; cmpl_idx = idx; cmpl_data = d; cmpl_exc = e;
      tick();
      cmpl_valid = 0; cmpl_exc = 0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [PW-1:0] idv [NVEC];
      logic [PW-1:0] fidx [DEPTH];
      logic [PW-1:0] ia, ib, ic, k, k1, k2, iz, prev, t, t2;
      @(negedge clk);
      repeat (2) tick();
      rst_n = 1;
      // R1: reset state
      for (int r = 0; r < NREG; r++) mdl[r] = DW'(r);
      chk("R1 alloc_idx", 32'(alloc_idx), 0);
      chk("R1 full", 32'(full), 0);
      chk("R1 exc_valid", 32'(exc_valid), 0);
      chk_arf("R1 arf reset");

      // R2/R4: table walk, completions in reverse program order
      for (int v = 0; v < NVEC; v++)
         alloc(PCW'(16'h40 + 4*v), VEC[v][AW+DW-1:DW], 1'b1, 1'b0, idv[v]);
      for (int v = 0; v < NVEC; v++) chk("R2 slot order", 32'(idv[v]), v);
      for (int v = NVEC-1; v >= 1; v--) cmpl(idv[v], VEC[v][DW-1:0], 1'b0);
      tick();
      chk_arf("R3 held by undone head");
      cmpl(idv[0], VEC[0][DW-1:0], 1'b0);
      repeat (NVEC + 1) tick();
      for (int v = 0; v < NVEC; v++) mdl[VEC[v][AW+DW-1:DW]] = VEC[v][DW-1:0];
      chk_arf("R4 program-order result");

      // R2/R3: one retire per edge, due one edge after head completes
      alloc(16'h80, 3'd1, 1'b1, 1'b0, ia);
      alloc(16'h84, 3'd1, 1'b1, 1'b0, ib);
      cmpl(ib, 8'hB2, 1'b0);
      cmpl(ia, 8'hA1, 1'b0);
      chk("R3 not before retire edge", 32'(arf_rd(1)), 32'(mdl[1]));
      tick();
      chk("R2 first retire", 32'(arf_rd(1)), 32'h A1);
      tick();
      chk("R2 second retire", 32'(arf_rd(1)), 32'h B2);
      mdl[1] = 8'hB2;

      // R5: fill, reject, drain
      for (int j = 0; j < DEPTH; j++) alloc(PCW'(16'h300 + j), AW'(j), 1'b1, 1'b0, fidx[j]);
      chk("R5 full set", 32'(full), 1);
      prev = alloc_idx;
      alloc(16'h3FF, 3'd3, 1'b1, 1'b0, t);
      chk("R5 rejected alloc idx", 32'(alloc_idx), 32'(prev));
      chk("R5 still full", 32'(full), 1);
      for (int j = 0; j < DEPTH; j++) cmpl(fidx[j], DW'(8'h80 + j), 1'b0);
      repeat (3) tick();
      for (int j = 0; j < DEPTH; j++) mdl[j] = DW'(8'h80 + j);
      chk("R5 full clear", 32'(full), 0);
      chk_arf("R5 drained results");

      // R6: completion to an invalid slot
      t = alloc_idx;
      cmpl(t, 8'h5A, 1'b0);
      alloc(16'h500, 3'd2, 1'b1, 1'b0, t2);
      repeat (3) tick();
      chk("R6 stray completion ignored", 32'(arf_rd(2)), 32'(mdl[2]));
      cmpl(t2, 8'h66, 1'b0);
      tick();
      mdl[2] = 8'h66;
      chk("R6 real completion retires", 32'(arf_rd(2)), 32'(mdl[2]));

      // R7/R8: precise exception
      alloc(16'h100, 3'd3, 1'b1, 1'b0, ia);
      alloc(16'h104, 3'd4, 1'b1, 1'b0, ib);
      alloc(16'h108, 3'd6, 1'b1, 1'b0, ic);
      cmpl(ic, 8'h77, 1'b0);
      cmpl(ia, 8'h33, 1'b0);
      cmpl(ib, 8'h44, 1'b1);
      mdl[3] = 8'h33;
      chk("R3 older slot retired", 32'(arf_rd(3)), 32'h33);
      chk("R7 no early pulse", 32'(exc_valid), 0);
      tick();
      chk("R7 exc_valid", 32'(exc_valid), 1);
      chk("R7 exc_pc", 32'(exc_pc), 32'h104);
      chk("R7 faulting result dropped", 32'(arf_rd(4)), 32'(mdl[4]));
      chk("R8 younger result dropped", 32'(arf_rd(6)), 32'(mdl[6]));
      chk("R8 tail at faulting slot", 32'(alloc_idx), 32'(ib));
      tick();
      chk("R7 pulse one cycle", 32'(exc_valid), 0);
      chk("R8 empty after flush", 32'(full), 0);

      // R9/R10: misprediction
      alloc(16'h200, 3'd0, 1'b0, 1'b0, k);
      alloc(16'h204, 3'd5, 1'b1, 1'b1, k1);
      alloc(16'h208, 3'd7, 1'b1, 1'b1, k2);
      cmpl(k2, 8'hEE, 1'b0);
      cmpl(k1, 8'hDD, 1'b0);
      tick();
      chk("R3 held behind branch", 32'(arf_rd(5)), 32'(mdl[5]));
      mp_valid = 1; mp_idx = k;
      tick();
      mp_valid = 0;
      chk("R9 tail after branch", 32'(alloc_idx), 32'(PW'(k + 1)));
      cmpl(k2, 8'h99, 1'b0);
      alloc(16'h20C, 3'd5, 1'b1, 1'b0, iz);
      chk("R9 new slot index", 32'(iz), 32'(PW'(k + 1)));
      cmpl(iz, 8'h5C, 1'b0);
      tick();
      mdl[5] = 8'h5C;
      chk("R9 branch retired, path resumes", 32'(arf_rd(5)), 32'h5C);
      chk("R10 squashed result never written", 32'(arf_rd(7)), 32'(mdl[7]));
      repeat (2) tick();
      chk_arf("R10 final state");
      chk("R9 empty at end", 32'(full), 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule